// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit executes the second byte of the bit-manipulation instruction group of an 8-bit accumulator CPU. One opcode byte names the operation class (shift/rotate, bit test, bit clear, bit set). It also names a 3-bit field that picks either the shift kind or the bit number, and a 3-bit operand code. The unit takes the opcode byte, the operand byte and the current flag byte in one cycle. One cycle later it returns the result byte, the new flag byte, a write-back enable, the operand code, memory access requests and the T-state count of the instruction.

The unit holds no register file and no memory port. The surrounding sequencer reads the operand named by the operand code and presents it on `operand`. When the code names the byte addressed by the HL pair, the sequencer first fetches that byte. The unit then signals a read, and a write-back when the class modifies data, so the sequencer can finish the read-modify-write.

Top module: `cbx_bit_unit`

## Requirements
- R1: Opcode bits 7:6 select the class: 00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set. Bits 5:3 are the shift kind or the bit number. Bits 2:0 are the operand code.
- R2: Shift kinds by bits 5:3: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left filling 0, 5 shift right keeping bit 7, 6 shift left filling 1, 7 shift right filling 0. The bit shifted out goes to carry (flag bit 0).
- R3: Flag byte layout is S=7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. After a shift, S, Y and X copy result bits 7, 5 and 3, and Z is set when the result is zero. P/V is set when the result has an even number of ones, and H and N are cleared.
- R4: A bit test sets Z and P/V when the tested bit is 0, otherwise clears both. It sets H, clears N and keeps C. S is set only for bit 7 with Z clear, Y only for bit 5 with Z clear, and X only for bit 3 with Z clear. The same rule holds for the memory operand.
- R5: A bit test has no write-back: `wb_en` is 0 and `result` equals the operand.
- R6: Bit clear returns the operand with the numbered bit forced to 0. Bit set returns it with that bit forced to 1. Both return `flags_in` unchanged.
- R7: `target_sel` repeats opcode bits 2:0. `mem_read` is 1 exactly for operand code 6. `mem_write` is 1 for code 6 in every class except the bit test. `wb_en` is 1 for every class except the bit test.
- R8: `cycles` is 8 for operand codes other than 6, 12 for a bit test on code 6, and 15 for the other classes on code 6.
- R9: Outputs are registered: they show the operation presented on a cycle with `in_valid` high at the next clock edge, and `out_valid` follows `in_valid` by one cycle. After reset every output is 0.
- R10: While `in_valid` is low, `result`, `flags_out`, `wb_en`, `target_sel`, `mem_read`, `mem_write` and `cycles` hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Opcode, operand and flags are presented this cycle |
| op_byte | input | 8 | Second opcode byte |
| operand | input | 8 | Operand byte, fetched by the sequencer |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Outputs carry a new result |
| result | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |
| wb_en | output | 1 | Result must be written to the operand |
| target_sel | output | 3 | Operand code of the instruction |
| mem_read | output | 1 | Operand is the byte addressed by HL |
| mem_write | output | 1 | Result must be stored to the byte addressed by HL |
| cycles | output | CYC_W | T-state count of the instruction |

## Verification
All 256 opcode bytes are swept with the operands 00, FF, 80, 01, 55 and AA, each with carry-in 0 and 1. The all-zero and all-one operands separate the zero and parity flags and the fill bits. The single-end operands 80 and 01 show which bit each shift moves into carry. The alternating 55 and AA operands give each bit test a 0 and a 1 at every position, which separates the undocumented S, Y and X rules for bit numbers 7, 5 and 3. Random opcode, operand and flag bytes are mixed in, and idle cycles with changing inputs check that the outputs hold.

// File: rtl/cbx_pkg.sv
// Shared types and constants of the bit-manipulation execution unit.
// Assumes an 8-bit data path and the conventional flag byte layout.
package cbx_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

    // Flag byte bit positions; the sequencer decodes them at these places
    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_Y  = 5;
    localparam int FLG_H  = 4;
    localparam int FLG_X  = 3;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;
    localparam int FLG_C  = 0;

    localparam logic [SEL_W-1:0] TGT_MEM = 3'd6;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_TEST  = 2'b01,
        CLS_CLEAR = 2'b10,
        CLS_SET   = 2'b11
    } cbx_class_e;

    typedef enum logic [SEL_W-1:0] {
        SH_ROLC = 3'd0,
        SH_RORC = 3'd1,
        SH_ROLT = 3'd2,
        SH_RORT = 3'd3,
        SH_SHLZ = 3'd4,
        SH_SHRA = 3'd5,
        SH_SHLO = 3'd6,
        SH_SHRZ = 3'd7
    } cbx_shift_e;

    typedef struct packed {
        cbx_class_e       cls;
        logic [SEL_W-1:0] sel;
        logic [SEL_W-1:0] tgt;
        logic             is_mem;
    } cbx_dec_t;

endpackage

// File: rtl/cbx_decode.sv
// Opcode decoder: splits the second opcode byte into class, selector and
// operand code, and looks up the T-state count in a 256-entry table that is
// built by generate. Purely combinational.
module cbx_decode
    import cbx_pkg::*;
#(
    parameter int               CYC_W       = 5,
    parameter logic [CYC_W-1:0] CYC_REG     = CYC_W'(8),
    parameter logic [CYC_W-1:0] CYC_BIT_MEM = CYC_W'(12),
    parameter logic [CYC_W-1:0] CYC_MEM     = CYC_W'(15)
) (
    input  logic [DATA_W-1:0] op_byte,
    output cbx_dec_t          dec,
    output logic [CYC_W-1:0]  cyc
);

    localparam int N_OPS = 1 << DATA_W;

    logic [CYC_W-1:0] cyc_tab [N_OPS];

    // Field split of the opcode byte
    always_comb begin
        dec.cls    = cbx_class_e'(op_byte[7:6]);
        dec.sel    = op_byte[5:3];
        dec.tgt    = op_byte[2:0];
        dec.is_mem = (op_byte[2:0] == TGT_MEM);
    end

    // One table entry per opcode value, computed from the opcode's own fields
    for (genvar g = 0; g < N_OPS; g++) begin : g_cyc
        localparam logic [DATA_W-1:0] OPC = DATA_W'(g);
        localparam bit OPC_MEM  = (OPC[2:0] == TGT_MEM);
        localparam bit OPC_TEST = (OPC[7:6] == 2'b01);
        assign cyc_tab[g] = !OPC_MEM ? CYC_REG : (OPC_TEST ? CYC_BIT_MEM : CYC_MEM);
    end

    // Table lookup
    assign cyc = cyc_tab[op_byte];

endmodule

// File: rtl/cbx_shift.sv
// Shift/rotate datapath: applies one of eight shift kinds to the operand and
// builds the full flag byte from the result. Assumes the incoming carry is
// flag bit 0. Purely combinational.
module cbx_shift
    import cbx_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    input  cbx_shift_e        kind,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] flags
);

    logic cout;

    // Shift kind selection; cout is the bit that leaves the byte
    always_comb begin
        res  = a;
        cout = 1'b0;
        unique case (kind)
            SH_ROLC: begin res = {a[6:0], a[7]}; cout = a[7]; end
            SH_RORC: begin res = {a[0], a[7:1]}; cout = a[0]; end
            SH_ROLT: begin res = {a[6:0], cin};  cout = a[7]; end
            SH_RORT: begin res = {cin, a[7:1]};  cout = a[0]; end
            SH_SHLZ: begin res = {a[6:0], 1'b0}; cout = a[7]; end
            SH_SHRA: begin res = {a[7], a[7:1]}; cout = a[0]; end
            SH_SHLO: begin res = {a[6:0], 1'b1}; cout = a[7]; end
            SH_SHRZ: begin res = {1'b0, a[7:1]}; cout = a[0]; end
            default: begin res = a;              cout = cin;  end
        endcase
    end

    // Flag byte derived from the shifted result
    always_comb begin
        flags         = '0;
        flags[FLG_S]  = res[7];
        flags[FLG_Z]  = (res == '0);
        flags[FLG_Y]  = res[5];
        flags[FLG_H]  = 1'b0;
        flags[FLG_X]  = res[3];
        flags[FLG_PV] = ~^res;
        flags[FLG_N]  = 1'b0;
        flags[FLG_C]  = cout;
    end

endmodule

// File: rtl/cbx_bitop.sv
// Single-bit datapath for the test, clear and set classes. Builds a one-hot
// mask from the bit number and returns result and flags for the class given.
// Assumes it is only consulted for those three classes. Purely combinational.
module cbx_bitop
    import cbx_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] flags_in,
    input  cbx_class_e        cls,
    input  logic [SEL_W-1:0]  bitn,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] flags
);

    logic [DATA_W-1:0] mask;
    logic              zero_bit;

    // One-hot mask, one comparator per bit position
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (bitn == SEL_W'(g));
    end

    // Tested bit reads as zero
    assign zero_bit = ((a & mask) == '0);

    // Result per class; the test class leaves the operand as it is
    always_comb begin
        unique case (cls)
            CLS_CLEAR: res = a & ~mask;
            CLS_SET:   res = a | mask;
            default:   res = a;
        endcase
    end

    // Flags: test class rebuilds them, clear and set pass them through
    always_comb begin
        flags = flags_in;
        if (cls == CLS_TEST) begin
            flags[FLG_S]  = mask[7] & ~zero_bit;
            flags[FLG_Z]  = zero_bit;
            flags[FLG_Y]  = mask[5] & ~zero_bit;
            flags[FLG_H]  = 1'b1;
            flags[FLG_X]  = mask[3] & ~zero_bit;
            flags[FLG_PV] = zero_bit;
            flags[FLG_N]  = 1'b0;
            flags[FLG_C]  = flags_in[FLG_C];
        end
    end

endmodule

// File: rtl/cbx_bit_unit.sv
// Top of the bit-manipulation execution unit. Decodes the opcode byte, runs
// the shift and single-bit datapaths in parallel, picks one by class and
// registers every output once per valid input. Assumes the sequencer has
// already fetched the operand (including the memory byte for code 6).
module cbx_bit_unit
    import cbx_pkg::*;
#(
    parameter int               CYC_W       = 5,
    parameter logic [CYC_W-1:0] CYC_REG     = CYC_W'(8),
    parameter logic [CYC_W-1:0] CYC_BIT_MEM = CYC_W'(12),
    parameter logic [CYC_W-1:0] CYC_MEM     = CYC_W'(15)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       op_byte,
    input  logic [7:0]       operand,
    input  logic [7:0]       flags_in,
    output logic             out_valid,
    output logic [7:0]       result,
    output logic [7:0]       flags_out,
    output logic             wb_en,
    output logic [2:0]       target_sel,
    output logic             mem_read,
    output logic             mem_write,
    output logic [CYC_W-1:0] cycles
);

    cbx_dec_t          dec;
    logic [CYC_W-1:0]  nxt_cyc;
    logic [DATA_W-1:0] sh_res, sh_flg;
    logic [DATA_W-1:0] bo_res, bo_flg;
    logic [DATA_W-1:0] nxt_res, nxt_flg;
    logic              nxt_wb, nxt_mwr;

    cbx_decode #(
        .CYC_W       (CYC_W),
        .CYC_REG     (CYC_REG),
        .CYC_BIT_MEM (CYC_BIT_MEM),
        .CYC_MEM     (CYC_MEM)
    ) u_decode (
        .op_byte (op_byte),
        .dec     (dec),
        .cyc     (nxt_cyc)
    );

    cbx_shift u_shift (
        .a     (operand),
        .cin   (flags_in[FLG_C]),
        .kind  (cbx_shift_e'(dec.sel)),
        .res   (sh_res),
        .flags (sh_flg)
    );

    cbx_bitop u_bitop (
        .a        (operand),
        .flags_in (flags_in),
        .cls      (dec.cls),
        .bitn     (dec.sel),
        .res      (bo_res),
        .flags    (bo_flg)
    );

    // Class select and write-back decisions
    always_comb begin
        nxt_res = (dec.cls == CLS_SHIFT) ? sh_res : bo_res;
        nxt_flg = (dec.cls == CLS_SHIFT) ? sh_flg : bo_flg;
        nxt_wb  = (dec.cls != CLS_TEST);
        nxt_mwr = dec.is_mem && nxt_wb;
    end

    // Output registers, loaded only on a valid input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            flags_out  <= '0;
            wb_en      <= 1'b0;
            target_sel <= '0;
            mem_read   <= 1'b0;
            mem_write  <= 1'b0;
            cycles     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= nxt_res;
                flags_out  <= nxt_flg;
                wb_en      <= nxt_wb;
                target_sel <= dec.tgt;
                mem_read   <= dec.is_mem;
                mem_write  <= nxt_mwr;
                cycles     <= nxt_cyc;
            end
        end
    end

endmodule

// File: rtl/cbx_bit_unit_checker.sv
// Property checker for cbx_bit_unit, attached by bind. Observes ports only.
module cbx_bit_unit_checker #(
    parameter int               CYC_W       = 5,
    parameter logic [CYC_W-1:0] CYC_REG     = CYC_W'(8),
    parameter logic [CYC_W-1:0] CYC_BIT_MEM = CYC_W'(12),
    parameter logic [CYC_W-1:0] CYC_MEM     = CYC_W'(15)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       op_byte,
    input logic [7:0]       operand,
    input logic [7:0]       flags_in,
    input logic             out_valid,
    input logic [7:0]       result,
    input logic [7:0]       flags_out,
    input logic             wb_en,
    input logic [2:0]       target_sel,
    input logic             mem_read,
    input logic             mem_write,
    input logic [CYC_W-1:0] cycles
);

    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    p_test_nowb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(op_byte[7:6]) == 2'b01))
        |-> (!wb_en && (result == $past(operand))));

    p_clrset_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_byte[7]))
        |-> (flags_out == $past(flags_in)));

    p_shift_hn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(op_byte[7:6]) == 2'b00))
        |-> (!flags_out[4] && !flags_out[1]));

    p_test_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(op_byte[7:6]) == 2'b01))
        |-> (flags_out[4] && !flags_out[1] && (flags_out[6] == flags_out[2])
             && (flags_out[0] == $past(flags_in[0]))));

    p_mem_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mem_write) |-> (mem_read && wb_en && (target_sel == 3'd6)));

    p_reg_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mem_read) |-> (cycles == CYC_REG));

    p_mem_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mem_read) |-> (cycles == (wb_en ? CYC_MEM : CYC_BIT_MEM)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid))
        |-> ($stable(result) && $stable(flags_out) && $stable(wb_en)
             && $stable(target_sel) && $stable(mem_read) && $stable(mem_write)
             && $stable(cycles)));

endmodule

bind cbx_bit_unit cbx_bit_unit_checker #(
    .CYC_W       (CYC_W),
    .CYC_REG     (CYC_REG),
    .CYC_BIT_MEM (CYC_BIT_MEM),
    .CYC_MEM     (CYC_MEM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_byte    (op_byte),
    .operand    (operand),
    .flags_in   (flags_in),
    .out_valid  (out_valid),
    .result     (result),
    .flags_out  (flags_out),
    .wb_en      (wb_en),
    .target_sel (target_sel),
    .mem_read   (mem_read),
    .mem_write  (mem_write),
    .cycles     (cycles)
);

// File: tb/cbx_bit_unit_bench.sv
// Self-checking bench: full opcode sweep over directed operands, then seeded
// random vectors and idle-hold checks, against a bench-side model.
module cbx_bit_unit_bench;

    localparam int CYC_W = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [7:0]       op_byte, operand, flags_in;
    logic             out_valid, wb_en, mem_read, mem_write;
    logic [7:0]       result, flags_out;
    logic [2:0]       target_sel;
    logic [CYC_W-1:0] cycles;

    int n_run  = 0;
    int n_fail = 0;

    always #4ns clk = ~clk;

    cbx_bit_unit u_cbx_bit_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_byte    (op_byte),
        .operand    (operand),
        .flags_in   (flags_in),
        .out_valid  (out_valid),
        .result     (result),
        .flags_out  (flags_out),
        .wb_en      (wb_en),
        .target_sel (target_sel),
        .mem_read   (mem_read),
        .mem_write  (mem_write),
        .cycles     (cycles)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (op %02h opd %02h fl %02h)",
                     tag, act, exp, op_byte, operand, flags_in);
        end
    endtask

    // Model: {result, flags, wb, mem_read, mem_write, cycles}
    function automatic logic [23:0] model(input logic [7:0] op, input logic [7:0] a,
                                          input logic [7:0] f);
        logic [1:0] cls;
        logic [2:0] s, t;
        logic [7:0] r, fl;
        logic       c, z;
        logic [4:0] cy;
        cls = op[7:6];
        s   = op[5:3];
        t   = op[2:0];
        r   = a;
        fl  = f;
        c   = 1'b0;
        if (cls == 2'd0) begin
            case (s)
                3'd0: begin r = (a << 1) | (a >> 7); c = a[7]; end
                3'd1: begin r = (a >> 1) | (a << 7); c = a[0]; end
                3'd2: begin r = (a << 1) | {7'd0, f[0]}; c = a[7]; end
                3'd3: begin r = (a >> 1) | {f[0], 7'd0}; c = a[0]; end
                3'd4: begin r = a << 1; c = a[7]; end
                3'd5: begin r = (a >> 1) | (a & 8'h80); c = a[0]; end
                3'd6: begin r = (a << 1) | 8'h01; c = a[7]; end
                default: begin r = a >> 1; c = a[0]; end
            endcase
            fl = {r[7], (r == 8'h00), r[5], 1'b0, r[3], ~^r, 1'b0, c};
        end else if (cls == 2'd1) begin
            z  = ((a >> s) & 8'h01) == 8'h00;
            fl = {(s == 3'd7) && !z, z, (s == 3'd5) && !z, 1'b1,
                  (s == 3'd3) && !z, z, 1'b0, f[0]};
        end else if (cls == 2'd2) begin
            r = a & ~(8'h01 << s);
        end else begin
            r = a | (8'h01 << s);
        end
        if (t != 3'd6)       cy = 5'd8;
        else if (cls == 2'd1) cy = 5'd12;
        else                 cy = 5'd15;
        return {r, fl, cls != 2'd1, t == 3'd6, (t == 3'd6) && (cls != 2'd1), cy};
    endfunction

    // Drive one vector at a falling edge, check at the next falling edge
    task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [7:0] f);
        logic [23:0] e;
        string       rt, ft;
        op_byte  = op;
        operand  = a;
        flags_in = f;
        in_valid = 1'b1;
        e = model(op, a, f);
        @(negedge clk);
        case (op[7:6])
            2'd0: begin rt = "R1/R2"; ft = "R3"; end
            2'd1: begin rt = "R1/R5"; ft = "R4"; end
            default: begin rt = "R1/R6"; ft = "R6"; end
        endcase
        chk("R9 out_valid", 32'(out_valid), 32'd1);
        chk(rt, 32'(result), 32'(e[23:16]));
        chk(ft, 32'(flags_out), 32'(e[15:8]));
        chk("R5/R7 wb_en", 32'(wb_en), 32'(e[7]));
        chk("R7 mem_read", 32'(mem_read), 32'(e[6]));
        chk("R7 mem_write", 32'(mem_write), 32'(e[5]));
        chk("R7 target_sel", 32'(target_sel), 32'(op[2:0]));
        chk("R8 cycles", 32'(cycles), 32'(e[4:0]));
    endtask

    // One idle cycle with scrambled inputs; everything must hold
    task automatic idle_hold();
        logic [7:0]       r0, f0;
        logic [CYC_W-1:0] c0;
        logic [5:0]       m0;
        r0 = result;
        f0 = flags_out;
        c0 = cycles;
        m0 = {wb_en, mem_read, mem_write, target_sel};
        in_valid = 1'b0;
        op_byte  = 8'($urandom);
        operand  = 8'($urandom);
        flags_in = 8'($urandom);
        @(negedge clk);
        chk("R9 idle out_valid", 32'(out_valid), 32'd0);
        chk("R10 result hold", 32'(result), 32'(r0));
        chk("R10 flags hold", 32'(flags_out), 32'(f0));
        chk("R10 cycles hold", 32'(cycles), 32'(c0));
        chk("R10 ctrl hold", 32'({wb_en, mem_read, mem_write, target_sel}), 32'(m0));
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8ns * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] pats [6];
        pats = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h55, 8'hAA};
        void'($urandom(32'd2718));
        rst_n    = 1'b0;
        in_valid = 1'b1;
        op_byte  = 8'hC7;
        operand  = 8'h12;
        flags_in = 8'h34;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset out_valid", 32'(out_valid), 32'd0);
        chk("R9 reset result", 32'(result), 32'd0);
        chk("R9 reset flags", 32'(flags_out), 32'd0);
        chk("R9 reset ctrl", 32'({wb_en, mem_read, mem_write, target_sel, cycles}), 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        // Full opcode sweep over directed operands and both carry values
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 2; c++) begin
                for (int op = 0; op < 256; op++) begin
                    apply(8'(op), pats[p], {7'($urandom), 1'(c)});
                end
                idle_hold();
            end
        end

        // Seeded random vectors with occasional idle cycles
        for (int k = 0; k < 3000; k++) begin
            apply(8'($urandom), 8'($urandom), 8'($urandom));
            if ((k % 50) == 0) idle_hold();
        end

        // Directed corners: bit test of bit 7, 5 and 3 set, memory forms
        apply(8'h7E, 8'h80, 8'h00);
        apply(8'h6E, 8'h20, 8'h01);
        apply(8'h5E, 8'h08, 8'h00);
        apply(8'h46, 8'hFE, 8'hFF);
        apply(8'h3E, 8'h01, 8'h00);
        idle_hold();
        summary();
    end

endmodule